// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator processor. A micro-step counter runs through the steps of each instruction. On every step the block builds a microcode address from three parts: the current step, the 4-bit opcode held in the instruction register, and the Zero and Carry flags. A case-based lookup turns that address into a control word. The word's strobes steer a shared bus, the program counter, the memory address register, RAM, the accumulator, the ALU and the output register. The datapath itself lies outside this block.

Every instruction starts with the same two fetch steps. One or two execute steps follow. A return bit in the control word then sends the counter back to the first fetch step. The flags are part of the microcode address, so a conditional jump needs no decode logic of its own: the taken and the not-taken case are simply different microcode entries. A halt instruction stops the counter and masks every strobe until reset.

Top module: `ucseq_control_unit`

## Requirements
- R1: A synchronous active-high `rst` returns the counter to the first fetch step, also when it arrives in the middle of an instruction. In the cycle after reset is released, only `pc_to_bus` and `mar_load` are high, and `halt` is low.
- R2: Every opcode and every flag value gives the same fetch. Step 0 drives `pc_to_bus`+`mar_load`. Step 1 drives `ram_to_bus`+`ir_load`+`pc_inc`. Execution starts at step 2.
- R3: LDA (opcode 0001) drives `ir_to_bus`+`mar_load` at step 2 and `ram_to_bus`+`a_load` at step 3. The next cycle is fetch step 0.
- R4: ADD (0010) drives `alu_to_bus`+`a_load` with `alu_sub` low. SUB (0011) drives the same strobes with `alu_sub` high. Each is one execute step, followed by fetch step 0.
- R5: STA (0100) drives `ir_to_bus`+`mar_load` at step 2 and `a_to_bus`+`ram_write` at step 3. The next cycle is fetch step 0.
- R6: LDI (0101) drives `ir_to_bus`+`a_load`. OUT (1110) drives `a_to_bus`+`out_load`. Each is one execute step.
- R7: JMP (0110) drives `ir_to_bus`+`pc_load` whatever the flags are.
- R8: JC (0111) drives `ir_to_bus`+`pc_load` only when `flag_carry` is 1. Otherwise its execute step has every strobe low. `flag_zero` has no effect on it.
- R9: JZ (1000) drives `ir_to_bus`+`pc_load` only when `flag_zero` is 1. Otherwise its execute step has every strobe low. `flag_carry` has no effect on it.
- R10: NOP (0000) and the unused opcodes 1001 to 1101 have one execute step with every strobe low, and then return to fetch step 0.
- R11: HLT (1111) raises `halt` at step 2. From then on `halt` stays high, every other strobe stays low, and the counter holds, even if the opcode changes. Only reset clears the halt.
- R12: In every step, at most one of `pc_to_bus`, `ram_to_bus`, `ir_to_bus`, `a_to_bus` and `alu_to_bus` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode nibble from the instruction register |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| pc_to_bus | output | 1 | Program counter drives the bus |
| mar_load | output | 1 | Memory address register loads from the bus |
| ram_to_bus | output | 1 | RAM read onto the bus |
| ram_write | output | 1 | RAM write from the bus |
| ir_load | output | 1 | Instruction register loads from the bus |
| ir_to_bus | output | 1 | Instruction operand field drives the bus |
| pc_inc | output | 1 | Program counter increments |
| pc_load | output | 1 | Program counter loads from the bus |
| a_load | output | 1 | Accumulator loads from the bus |
| a_to_bus | output | 1 | Accumulator drives the bus |
| alu_to_bus | output | 1 | ALU result drives the bus |
| alu_sub | output | 1 | ALU subtracts when high, adds when low |
| out_load | output | 1 | Output register loads from the bus |
| halt | output | 1 | Processor halted |

## Verification
Each defined opcode is run through a complete instruction, with the strobe vector compared at every step. This separates the one-step instructions from the two-step ones and shows the return to fetch. Both conditional jumps are run with the deciding flag set and cleared, while the other flag is held opposite. This shows that each jump's address entry reads the correct flag bit. The unused opcodes are run with both flags high, to show they fall back to the empty word. Halt is followed by a change of opcode and then a reset, which shows that the halt latches and that only reset clears it. A reset in the middle of an instruction shows that the counter restarts.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int STEP_W = 3;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 2;
    localparam int ADDR_W = STEP_W + OP_W + FLAG_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_STA = 4'h4,
        OP_LDI = 4'h5,
        OP_JMP = 4'h6,
        OP_JC  = 4'h7,
        OP_JZ  = 4'h8,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    typedef struct packed {
        logic pc_to_bus;
        logic mar_load;
        logic ram_to_bus;
        logic ram_write;
        logic ir_load;
        logic ir_to_bus;
        logic pc_inc;
        logic pc_load;
        logic a_load;
        logic a_to_bus;
        logic alu_to_bus;
        logic alu_sub;
        logic out_load;
        logic halt;
        logic step_clear;
    } ctrl_word_t;

endpackage

// File: rtl/ucseq_rom.sv
module ucseq_rom
    import ucseq_pkg::*;
#(
    parameter int STEP_W = ucseq_pkg::STEP_W,
    parameter int OP_W   = ucseq_pkg::OP_W,
    parameter int FLAG_W = ucseq_pkg::FLAG_W,
    localparam int ADDR_W = STEP_W + OP_W + FLAG_W
) (
    input  logic [ADDR_W-1:0] addr,
    output ctrl_word_t        word
);

    localparam logic [STEP_W-1:0] ST_FETCH_A = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_FETCH_B = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_EXEC_A  = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_EXEC_B  = STEP_W'(3);

    logic [STEP_W-1:0] step;
    logic [OP_W-1:0]   op;
    logic              zf;
    logic              cf;

    // address layout: {step, opcode, zero, carry}
    assign step = addr[ADDR_W-1 -: STEP_W];
    assign op   = addr[FLAG_W +: OP_W];
    assign zf   = addr[1];
    assign cf   = addr[0];

    always_comb begin
        word = '0;
        case (step)
            ST_FETCH_A: begin
                word.pc_to_bus = 1'b1;
                word.mar_load  = 1'b1;
            end
            ST_FETCH_B: begin
                word.ram_to_bus = 1'b1;
                word.ir_load    = 1'b1;
                word.pc_inc     = 1'b1;
            end
            ST_EXEC_A: begin
                word.step_clear = 1'b1;
                case (op)
                    OP_LDA, OP_STA: begin
                        word.ir_to_bus  = 1'b1;
                        word.mar_load   = 1'b1;
                        word.step_clear = 1'b0;
                    end
                    OP_ADD: begin
                        word.alu_to_bus = 1'b1;
                        word.a_load     = 1'b1;
                    end
                    OP_SUB: begin
                        word.alu_to_bus = 1'b1;
                        word.alu_sub    = 1'b1;
                        word.a_load     = 1'b1;
                    end
                    OP_LDI: begin
                        word.ir_to_bus = 1'b1;
                        word.a_load    = 1'b1;
                    end
                    OP_JMP: begin
                        word.ir_to_bus = 1'b1;
                        word.pc_load   = 1'b1;
                    end
                    OP_JC: begin
                        word.ir_to_bus = cf;
                        word.pc_load   = cf;
                    end
                    OP_JZ: begin
                        word.ir_to_bus = zf;
                        word.pc_load   = zf;
                    end
                    OP_OUT: begin
                        word.a_to_bus = 1'b1;
                        word.out_load = 1'b1;
                    end
                    OP_HLT: begin
                        word.halt       = 1'b1;
                        word.step_clear = 1'b0;
                    end
                    default: ;
                endcase
            end
            ST_EXEC_B: begin
                word.step_clear = 1'b1;
                case (op)
                    OP_LDA: begin
                        word.ram_to_bus = 1'b1;
                        word.a_load     = 1'b1;
                    end
                    OP_STA: begin
                        word.a_to_bus  = 1'b1;
                        word.ram_write = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: word.step_clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/ucseq_step_ctr.sv
module ucseq_step_ctr #(
    parameter int STEP_W = ucseq_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_clear,
    input  logic              halt_req,
    output logic [STEP_W-1:0] step_q,
    output logic              halted_q
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              halted;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.halted || halt_req) begin
            state_d.halted = 1'b1;
        end else if (step_clear) begin
            state_d.step = '0;
        end else begin
            state_d.step = state_q.step + 1'b1;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign step_q   = state_q.step;
    assign halted_q = state_q.halted;

endmodule

// File: rtl/ucseq_control_unit.sv
module ucseq_control_unit
    import ucseq_pkg::*;
#(
    parameter int STEP_W = ucseq_pkg::STEP_W,
    parameter int OP_W   = ucseq_pkg::OP_W,
    parameter int FLAG_W = ucseq_pkg::FLAG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            flag_zero,
    input  logic            flag_carry,
    output logic            pc_to_bus,
    output logic            mar_load,
    output logic            ram_to_bus,
    output logic            ram_write,
    output logic            ir_load,
    output logic            ir_to_bus,
    output logic            pc_inc,
    output logic            pc_load,
    output logic            a_load,
    output logic            a_to_bus,
    output logic            alu_to_bus,
    output logic            alu_sub,
    output logic            out_load,
    output logic            halt
);

    localparam int ADDR_W = STEP_W + OP_W + FLAG_W;

    logic [STEP_W-1:0] step_q;
    logic              halted_q;
    logic [ADDR_W-1:0] rom_addr;
    ctrl_word_t        rom_word;
    ctrl_word_t        out_word;

    assign rom_addr = {step_q, opcode, flag_zero, flag_carry};

    ucseq_rom #(
        .STEP_W (STEP_W),
        .OP_W   (OP_W),
        .FLAG_W (FLAG_W)
    ) rom_i (
        .addr (rom_addr),
        .word (rom_word)
    );

    ucseq_step_ctr #(
        .STEP_W (STEP_W)
    ) ctr_i (
        .clk        (clk),
        .rst        (rst),
        .step_clear (rom_word.step_clear),
        .halt_req   (rom_word.halt),
        .step_q     (step_q),
        .halted_q   (halted_q)
    );

    always_comb begin
        out_word = rom_word;
        if (halted_q) begin
            out_word      = '0;
            out_word.halt = 1'b1;
        end
    end

    assign pc_to_bus  = out_word.pc_to_bus;
    assign mar_load   = out_word.mar_load;
    assign ram_to_bus = out_word.ram_to_bus;
    assign ram_write  = out_word.ram_write;
    assign ir_load    = out_word.ir_load;
    assign ir_to_bus  = out_word.ir_to_bus;
    assign pc_inc     = out_word.pc_inc;
    assign pc_load    = out_word.pc_load;
    assign a_load     = out_word.a_load;
    assign a_to_bus   = out_word.a_to_bus;
    assign alu_to_bus = out_word.alu_to_bus;
    assign alu_sub    = out_word.alu_sub;
    assign out_load   = out_word.out_load;
    assign halt       = out_word.halt;

endmodule

// File: rtl/ucseq_control_unit_chk.sv
module ucseq_control_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opcode,
    input logic       flag_zero,
    input logic       flag_carry,
    input logic       pc_to_bus,
    input logic       mar_load,
    input logic       ram_to_bus,
    input logic       ram_write,
    input logic       ir_load,
    input logic       ir_to_bus,
    input logic       pc_inc,
    input logic       pc_load,
    input logic       a_load,
    input logic       a_to_bus,
    input logic       alu_to_bus,
    input logic       alu_sub,
    input logic       out_load,
    input logic       halt
);

    assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_to_bus && mar_load && !halt));

    assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> (ram_to_bus && pc_inc));

    assert_alu_select_R4: assert property (@(posedge clk) disable iff (rst)
        alu_sub |-> (alu_to_bus && a_load));

    assert_store_source_R5: assert property (@(posedge clk) disable iff (rst)
        ram_write |-> (a_to_bus && !ram_to_bus));

    assert_out_source_R6: assert property (@(posedge clk) disable iff (rst)
        out_load |-> a_to_bus);

    assert_jc_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (pc_load && opcode == 4'b0111) |-> flag_carry);

    assert_jz_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (pc_load && opcode == 4'b1000) |-> flag_zero);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        halt |-> !(pc_to_bus || mar_load || ram_to_bus || ram_write || ir_load ||
                   ir_to_bus || pc_inc || pc_load || a_load || a_to_bus ||
                   alu_to_bus || alu_sub || out_load));

    assert_one_driver_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_to_bus, ram_to_bus, ir_to_bus, a_to_bus, alu_to_bus}));

endmodule

bind ucseq_control_unit ucseq_control_unit_chk chk_i (.*);

// File: tb/ucseq_control_unit_tb_top.sv
module ucseq_control_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [13:0] M_PCO  = 14'h2000;
    localparam logic [13:0] M_MARI = 14'h1000;
    localparam logic [13:0] M_RAMO = 14'h0800;
    localparam logic [13:0] M_RAMW = 14'h0400;
    localparam logic [13:0] M_IRI  = 14'h0200;
    localparam logic [13:0] M_IRO  = 14'h0100;
    localparam logic [13:0] M_PCI  = 14'h0080;
    localparam logic [13:0] M_PCL  = 14'h0040;
    localparam logic [13:0] M_AI   = 14'h0020;
    localparam logic [13:0] M_AO   = 14'h0010;
    localparam logic [13:0] M_ALUO = 14'h0008;
    localparam logic [13:0] M_SUB  = 14'h0004;
    localparam logic [13:0] M_OUTI = 14'h0002;
    localparam logic [13:0] M_HLT  = 14'h0001;
    localparam logic [13:0] FETCH0 = M_PCO | M_MARI;
    localparam logic [13:0] FETCH1 = M_RAMO | M_IRI | M_PCI;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       flag_zero = 1'b0;
    logic       flag_carry = 1'b0;
    logic pc_to_bus, mar_load, ram_to_bus, ram_write, ir_load, ir_to_bus, pc_inc;
    logic pc_load, a_load, a_to_bus, alu_to_bus, alu_sub, out_load, halt;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ucseq_control_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .pc_to_bus  (pc_to_bus),
        .mar_load   (mar_load),
        .ram_to_bus (ram_to_bus),
        .ram_write  (ram_write),
        .ir_load    (ir_load),
        .ir_to_bus  (ir_to_bus),
        .pc_inc     (pc_inc),
        .pc_load    (pc_load),
        .a_load     (a_load),
        .a_to_bus   (a_to_bus),
        .alu_to_bus (alu_to_bus),
        .alu_sub    (alu_sub),
        .out_load   (out_load),
        .halt       (halt)
    );

    function automatic logic [13:0] observed();
        return {pc_to_bus, mar_load, ram_to_bus, ram_write, ir_load, ir_to_bus, pc_inc,
                pc_load, a_load, a_to_bus, alu_to_bus, alu_sub, out_load, halt};
    endfunction

    task automatic check_word(input logic [13:0] exp, input string req, input string what);
        logic [13:0] got;
        got = observed();
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
        vectors++;
        if ($countones({pc_to_bus, ram_to_bus, ir_to_bus, a_to_bus, alu_to_bus}) > 1) begin
            misses++;
            $display("FAIL R12 %s bus drivers: got %h expected at most one", what, got);
        end
    endtask

    task automatic next_step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // starts and ends at fetch step 0, sampled 1 time unit after a falling edge
    task automatic run_op(input logic [3:0] op, input logic z, input logic c,
                          input logic [13:0] e2, input logic [13:0] e3, input bit two,
                          input string req, input string what);
        opcode = op;
        flag_zero = z;
        flag_carry = c;
        #1;
        check_word(FETCH0, "R2", {what, " step0"});
        next_step();
        check_word(FETCH1, "R2", {what, " step1"});
        next_step();
        check_word(e2, req, {what, " step2"});
        if (two) begin
            next_step();
            check_word(e3, req, {what, " step3"});
        end
        next_step();
        check_word(FETCH0, req, {what, " back to step0"});
    endtask

    task automatic test_reset_R1();
        do_reset();
        check_word(FETCH0, "R1", "after reset");
        run_op(4'h1, 1'b0, 1'b0, M_IRO | M_MARI, M_RAMO | M_AI, 1'b1, "R3", "lda");
        next_step();
        next_step();
        do_reset();
        check_word(FETCH0, "R1", "reset mid instruction");
    endtask

    task automatic test_alu_R4();
        run_op(4'h2, 1'b1, 1'b1, M_ALUO | M_AI, '0, 1'b0, "R4", "add");
        run_op(4'h3, 1'b0, 1'b1, M_ALUO | M_AI | M_SUB, '0, 1'b0, "R4", "sub");
    endtask

    task automatic test_mem_R3_R5();
        run_op(4'h1, 1'b1, 1'b0, M_IRO | M_MARI, M_RAMO | M_AI, 1'b1, "R3", "lda flags");
        run_op(4'h4, 1'b0, 1'b0, M_IRO | M_MARI, M_AO | M_RAMW, 1'b1, "R5", "sta");
    endtask

    task automatic test_move_R6();
        run_op(4'h5, 1'b0, 1'b0, M_IRO | M_AI, '0, 1'b0, "R6", "ldi");
        run_op(4'hE, 1'b1, 1'b0, M_AO | M_OUTI, '0, 1'b0, "R6", "out");
    endtask

    task automatic test_jumps_R7_R8_R9();
        run_op(4'h6, 1'b0, 1'b0, M_IRO | M_PCL, '0, 1'b0, "R7", "jmp flags 00");
        run_op(4'h6, 1'b1, 1'b1, M_IRO | M_PCL, '0, 1'b0, "R7", "jmp flags 11");
        run_op(4'h7, 1'b0, 1'b1, M_IRO | M_PCL, '0, 1'b0, "R8", "jc taken");
        run_op(4'h7, 1'b1, 1'b0, '0, '0, 1'b0, "R8", "jc not taken");
        run_op(4'h8, 1'b1, 1'b0, M_IRO | M_PCL, '0, 1'b0, "R9", "jz taken");
        run_op(4'h8, 1'b0, 1'b1, '0, '0, 1'b0, "R9", "jz not taken");
    endtask

    task automatic test_nop_R10();
        run_op(4'h0, 1'b0, 1'b0, '0, '0, 1'b0, "R10", "nop");
        for (int k = 9; k <= 13; k++) begin
            run_op(4'(k), 1'b1, 1'b1, '0, '0, 1'b0, "R10", $sformatf("unused %0h", k));
        end
    endtask

    task automatic test_halt_R11();
        opcode = 4'hF;
        flag_zero = 1'b0;
        flag_carry = 1'b0;
        #1;
        check_word(FETCH0, "R2", "hlt step0");
        next_step();
        check_word(FETCH1, "R2", "hlt step1");
        next_step();
        check_word(M_HLT, "R11", "hlt step2");
        next_step();
        check_word(M_HLT, "R11", "halted hold");
        opcode = 4'h1;
        flag_zero = 1'b1;
        flag_carry = 1'b1;
        #1;
        check_word(M_HLT, "R11", "halted opcode change");
        next_step();
        next_step();
        check_word(M_HLT, "R11", "halted later");
        do_reset();
        check_word(FETCH0, "R11", "reset clears halt");
        run_op(4'h2, 1'b0, 1'b0, M_ALUO | M_AI, '0, 1'b0, "R11", "resume after halt");
    endtask

    initial begin
        test_reset_R1();
        test_alu_R4();
        test_mem_R3_R5();
        test_move_R6();
        test_jumps_R7_R8_R9();
        test_nop_R10();
        test_halt_R11();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule